// File: doc/BRIEF.md
# Circular Pass-Window Center Finder

The block picks a sampling phase from the results of a phase sweep. It takes a map of `NPH` bits, one per equal phase step of a clock period, where a one means the phase passed. It returns the phase at the middle of the longest stretch of consecutive passing phases. Stretches are measured circularly, so phases at the top of the map and phases at the bottom of the map can form one window. The block only evaluates the map. Collecting the per-phase results is left to surrounding logic.

A one-cycle `start_i` pulse captures `map_i`. Maps that are all zero or all one finish on the edge that captures them. Any other map is walked over several cycles, one candidate window per cycle. Completion is marked by a single-cycle `done_o`. `phase_o` and `err_o` keep their values until the next search finishes.

Top module: `pwc_center_finder`

## Requirements
- R1: After reset, `done_o`, `err_o` and `phase_o` are all 0.
- R2: An all-zero map sets `err_o` to 1 and `phase_o` to 0 at completion. Any map with at least one set bit leaves `err_o` at 0.
- R3: An all-ones map gives `phase_o` = 0.
- R4: Bit k of the map stands for phase k. The result is the start index of the chosen window plus half its length (rounded down), taken modulo `NPH`. A map with a single set bit at k therefore gives k.
- R5: Windows are circular. Set bits at the top indices continue into set bits at index 0 upward as one window, and the midpoint can wrap past `NPH-1` to small values.
- R6: The walk begins at the lowest set bit and visits windows in order of rising start index. A window replaces the current best only when it is strictly longer, so the earlier window wins a tie.
- R7: Every accepted start produces exactly one `done_o` pulse, one cycle wide. For a map that is neither all zero nor all one, the pulse comes no more than `NPH/2+1` cycles after the start.
- R8: `phase_o` and `err_o` change only in the cycle where `done_o` is high. Otherwise they hold their last values.
- R9: A `start_i` pulse that arrives while a walk is running is ignored. That walk finishes with its own result, and the ignored pulse produces no extra `done_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | One-cycle request to evaluate `map_i` |
| map_i | input | NPH | Pass map, bit k = phase k passed |
| done_o | output | 1 | One-cycle completion pulse |
| phase_o | output | $clog2(NPH) | Chosen phase, held until the next completion |
| err_o | output | 1 | No passing phase in the last evaluated map |

## Verification
The assertions assume that `start_i` is a single-cycle pulse and that `map_i` is valid in the cycle it is high. They also assume `NPH` is a power of two, because the modulo reduction relies on that. The bench drives `start_i` high for exactly one cycle on a falling edge, with the map already stable. It raises a second pulse during a walk only on purpose, in the test for R9. The vectors are mostly 32-bit maps: single bits at both ends, wrapping windows, ties and alternating patterns. Each expected phase was worked out by hand from R4 to R6.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } pwc_state_e;
endpackage

// File: rtl/pwc_first_one.sv
// Index of the lowest set bit; zero when no bit is set.
module pwc_first_one #(
    parameter int NPH = 32,
    localparam int IW = $clog2(NPH)
) (
    input  logic [NPH-1:0] vec_i,
    output logic [IW-1:0]  idx_o
);
    always_comb begin
        idx_o = '0;
        for (int k = NPH - 1; k >= 0; k--) begin
            if (vec_i[k]) idx_o = IW'(k);
        end
    end
endmodule

// File: rtl/pwc_run_probe.sv
// Rotates the map right by idx, measures the run of ones at the bottom,
// then the gap of zeros above that run.
module pwc_run_probe #(
    parameter int NPH = 32,
    localparam int IW = $clog2(NPH),
    localparam int LW = IW + 1
) (
    input  logic [NPH-1:0] map_i,
    input  logic [IW-1:0]  idx_i,
    output logic [LW-1:0]  run_len_o,
    output logic [LW-1:0]  gap_o,
    output logic           more_o
);
    logic [2*NPH-1:0] dbl;
    logic [2*NPH-1:0] dbl_sh;
    logic [NPH-1:0]   rot;
    logic [NPH-1:0]   tail;
    logic             hit_run;
    logic             hit_gap;

    assign dbl    = {map_i, map_i};
    assign dbl_sh = dbl >> idx_i;
    assign rot    = dbl_sh[NPH-1:0];

    always_comb begin
        run_len_o = '0;
        hit_run   = 1'b0;
        for (int k = 0; k < NPH; k++) begin
            if (!hit_run) begin
                if (rot[k]) run_len_o = run_len_o + LW'(1);
                else        hit_run   = 1'b1;
            end
        end
    end

    assign tail   = rot >> run_len_o;
    assign more_o = |tail;

    always_comb begin
        gap_o   = '0;
        hit_gap = 1'b0;
        for (int k = 0; k < NPH; k++) begin
            if (!hit_gap) begin
                if (!tail[k]) gap_o   = gap_o + LW'(1);
                else          hit_gap = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwc_center_finder.sv
module pwc_center_finder #(
    parameter int NPH = 32,
    localparam int IW = $clog2(NPH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [NPH-1:0] map_i,
    output logic           done_o,
    output logic [IW-1:0]  phase_o,
    output logic           err_o
);
    import pwc_pkg::*;

    localparam int LW = IW + 1;
    localparam int SW = IW + 2;

    typedef struct packed {
        pwc_state_e     state;
        logic [NPH-1:0] map;
        logic [IW-1:0]  idx;
        logic [IW-1:0]  best_start;
        logic [LW-1:0]  best_len;
        logic [IW-1:0]  phase;
        logic           err;
        logic           done;
    } regs_t;

    regs_t r_d, r_q;

    logic [IW-1:0] low_idx;
    logic [LW-1:0] run_len;
    logic [LW-1:0] gap;
    logic          more;

    pwc_first_one #(.NPH(NPH)) u_first (
        .vec_i (map_i),
        .idx_o (low_idx)
    );

    pwc_run_probe #(.NPH(NPH)) u_probe (
        .map_i     (r_q.map),
        .idx_i     (r_q.idx),
        .run_len_o (run_len),
        .gap_o     (gap),
        .more_o    (more)
    );

    logic          better;
    logic [IW-1:0] cand_start;
    logic [LW-1:0] cand_len;
    logic [SW-1:0] next_idx;
    logic [IW-1:0] half_len;

    always_comb begin
        better     = run_len > r_q.best_len;
        cand_start = better ? r_q.idx : r_q.best_start;
        cand_len   = better ? run_len : r_q.best_len;
        next_idx   = SW'(r_q.idx) + SW'(run_len) + SW'(gap);
        half_len   = IW'(cand_len >> 1);

        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.map = map_i;
                    if (map_i == '0) begin
                        r_d.err   = 1'b1;
                        r_d.phase = '0;
                        r_d.done  = 1'b1;
                    end else if (&map_i) begin
                        r_d.err   = 1'b0;
                        r_d.phase = '0;
                        r_d.done  = 1'b1;
                    end else begin
                        r_d.state      = ST_SCAN;
                        r_d.idx        = low_idx;
                        r_d.best_start = '0;
                        r_d.best_len   = '0;
                    end
                end
            end
            ST_SCAN: begin
                r_d.best_start = cand_start;
                r_d.best_len   = cand_len;
                r_d.idx        = next_idx[IW-1:0];
                if (!more || next_idx >= SW'(NPH)) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                    r_d.err   = 1'b0;
                    r_d.phase = cand_start + half_len;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done_o  = r_q.done;
    assign phase_o = r_q.phase;
    assign err_o   = r_q.err;

    // Cycles spent walking; bounded by the skip distance of at least two per step.
    logic [IW+1:0] walk_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     walk_cnt_q <= '0;
        else if (r_q.state == ST_SCAN)  walk_cnt_q <= walk_cnt_q + 1'b1;
        else                            walk_cnt_q <= '0;
    end

    p_walk_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        walk_cnt_q <= (IW+2)'(NPH/2 + 1));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> !done_o);

    p_done_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(start_i) || $past(r_q.state == ST_SCAN)));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(phase_o) && $stable(err_o)));

    p_err_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (err_o == (r_q.map == '0)));
endmodule

// File: tb/pwc_center_finder_tb.sv
module pwc_center_finder_tb;
    localparam int NPH = 32;
    localparam int IW  = 5;
    localparam int NV  = 15;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start_i = 1'b0;
    logic [NPH-1:0] map_i = '0;
    logic           done_o;
    logic [IW-1:0]  phase_o;
    logic           err_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pwc_center_finder #(.NPH(NPH)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .map_i   (map_i),
        .done_o  (done_o),
        .phase_o (phase_o),
        .err_o   (err_o)
    );

    // {map, expected phase, expected err}
    localparam logic [37:0] VEC [NV] = '{
        {32'h0000_0000, 5'd0,  1'b1},   // R2
        {32'hFFFF_FFFF, 5'd0,  1'b0},   // R3
        {32'h0000_0001, 5'd0,  1'b0},   // R4
        {32'h8000_0000, 5'd31, 1'b0},   // R4
        {32'h0000_00F0, 5'd6,  1'b0},   // R4
        {32'h0000_0006, 5'd2,  1'b0},   // R4
        {32'h0000_FF0F, 5'd12, 1'b0},   // R6
        {32'hC000_0003, 5'd0,  1'b0},   // R5
        {32'hE000_0003, 5'd31, 1'b0},   // R5
        {32'hFFFF_0001, 5'd24, 1'b0},   // R5
        {32'h00F0_00F0, 5'd6,  1'b0},   // R6 tie
        {32'h5555_5555, 5'd0,  1'b0},   // R6 tie
        {32'h7FFF_FFFE, 5'd16, 1'b0},   // R4
        {32'h7FFF_FFFF, 5'd15, 1'b0},   // R4
        {32'hFFFF_FFFE, 5'd16, 1'b0}    // R4
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Pulse start, wait for done; returns latency in cycles (-1 on timeout).
    task automatic launch(input logic [NPH-1:0] m, output int lat);
        start_i = 1'b1;
        map_i   = m;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        if (!done_o) lat = -1;
    endtask

    initial begin
        #1500000;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        // R1: reset values
        check(done_o == 1'b0 && err_o == 1'b0 && phase_o == '0, "R1", {done_o, err_o, phase_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            launch(VEC[v][37:6], lat);
            check(lat > 0 && lat <= NPH/2 + 2, "R7 latency", lat, NPH/2 + 2);
            check(phase_o == VEC[v][5:1], "R4/R5/R6 phase", phase_o, VEC[v][5:1]);
            check(err_o == VEC[v][0], "R2 err", err_o, VEC[v][0]);
            @(negedge clk);
            check(done_o == 1'b0, "R7 single pulse", done_o, 0);
            repeat (3) @(negedge clk);
            check(phase_o == VEC[v][5:1] && err_o == VEC[v][0], "R8 hold", phase_o, VEC[v][5:1]);
        end

        // R8: error flag held, then cleared by next good result
        launch(32'h0, lat);
        repeat (4) @(negedge clk);
        check(err_o == 1'b1, "R8 err hold", err_o, 1);

        // R9: second start during a walk is ignored
        start_i = 1'b1;
        map_i   = 32'h0000_FF0F;
        @(negedge clk);
        start_i = 1'b1;
        map_i   = 32'h0000_0000;
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        while (!done_o && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        check(done_o == 1'b1 && phase_o == 5'd12 && err_o == 1'b0, "R9 ignored start", phase_o, 12);
        begin
            int extra = 0;
            for (int c = 0; c < 6; c++) begin
                @(negedge clk);
                if (done_o) extra++;
            end
            check(extra == 0, "R9 no extra done", extra, 0);
        end
        check(phase_o == 5'd12, "R9 result kept", phase_o, 12);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule